// File: doc/BRIEF.md
# Serial PHY Data Interface Controller

This block sits on the PHY side of a media-independent data interface and runs a 10 Mb/s one-bit serial link over the pins of the 4-bit interface. In serial mode only lane 0 of each data direction carries traffic. The other lanes and both error lines play no part. On each pulse of a 10 MHz transmit strobe, the block takes the MAC's lane-0 transmit bit toward the line. It chooses which strobe clocks the receive side: the recovered receive strobe while the receive pair carries a carrier, and the transmit strobe otherwise. It also drives carrier sense and collision according to the duplex setting.

The whole block runs in one system clock domain, and both strobes are one-cycle clock enables. On the receive side the block hunts for a run of alternating bits that ends in two consecutive ones. It then raises receive-data-valid and places each following bit on lane 0. Data-valid drops on the clock after the carrier is lost or a signal error is flagged. The receive strobe source may change only while data-valid is low. Carrier sense and collision are combinational functions of the transmit and receive activity flags. They are not aligned to either strobe.

Top module: `serphy_ctrl`

## Requirements
- R1: In serial mode, every transmit strobe loads `line_tx_act` with `mac_tx_en` and loads `line_tx_bit` with `mac_txd[0]`. When the enable is low, `line_tx_bit` is loaded with 0. Both outputs hold their values between strobes.
- R2: `mac_txd[3:1]` and `mac_tx_er` have no effect on any output. `mac_rx_er` and `mac_rxd[3:1]` stay at 0.
- R3: `rx_clk_sel` (1 = recovered strobe, 0 = transmit strobe) takes the value of `line_rx_act` one clock later, but only while `mac_rx_dv` is low. While data-valid is high it holds its value. `rx_clk_en` is whichever strobe is selected.
- R4: `mac_rx_dv` rises on the receive strobe whose bit is a 1 repeating a previous 1, provided that previous 1 ended a run of at least PRE_MIN alternating bits. A shorter run does not raise data-valid.
- R5: While `mac_rx_dv` is high, each selected receive strobe places `line_rx_bit` on `mac_rxd[0]`. The unselected strobe has no effect.
- R6: `mac_rx_dv` falls on the clock after `line_rx_act` goes low or `line_rx_err` goes high, without waiting for any strobe.
- R7: With `duplex_mode` = 2'b00 (half duplex), `mac_crs` is high when `line_tx_act` or `line_rx_act` is high.
- R8: With `duplex_mode` = 2'b01 (full duplex) or 2'b10 (repeater), `mac_crs` follows `line_rx_act` alone.
- R9: `mac_col` is high only in half duplex, and only while `line_tx_act` and `line_rx_act` are both high.
- R10: With `serial_mode` low, the serial path stays idle: `line_tx_act`, `mac_rx_dv`, `mac_crs`, `mac_col` and `rx_clk_sel` stay at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| serial_mode | input | 1 | 1 = one-bit serial pin mapping, 0 = nibble mapping (serial path idle) |
| duplex_mode | input | 2 | 00 half duplex, 01 full duplex, 10 repeater |
| tx_tick | input | 1 | 10 MHz transmit strobe (clock enable) |
| rec_tick | input | 1 | Recovered receive strobe (clock enable) |
| mac_tx_en | input | 1 | Transmit enable from the MAC |
| mac_tx_er | input | 1 | Transmit error from the MAC (ignored) |
| mac_txd | input | 4 | Transmit data lanes; lane 0 carries the serial bit |
| line_rx_bit | input | 1 | Decoded receive bit from the line |
| line_rx_act | input | 1 | Carrier present on the receive pair |
| line_rx_err | input | 1 | Signal error flagged on the receive pair |
| line_tx_bit | output | 1 | Serial bit sent toward the line |
| line_tx_act | output | 1 | Transmit activity toward the line |
| rx_clk_sel | output | 1 | Selected receive strobe source |
| rx_clk_en | output | 1 | Selected receive strobe |
| mac_rx_dv | output | 1 | Receive data valid |
| mac_rx_er | output | 1 | Receive error (held low) |
| mac_rxd | output | 4 | Receive data lanes; lane 0 carries the serial bit |
| mac_crs | output | 1 | Carrier sense |
| mac_col | output | 1 | Collision |

## Verification
The bench builds the block with PRE_MIN = 4. With that value, both sides of the preamble threshold can be driven in a handful of strobes: a run of three alternating bits before the closing pair fails, and a run of exactly four passes. A nine-bit run also pushes the run counter into saturation before the closing pair. Because of the small threshold, more of the run goes to the corner cases: source hold across carrier loss, signal-error abort, stray transmit strobes during data, and the nibble-mode idle state.

// File: rtl/serphy_ctrl.sv
module serphy_ctrl #(
  parameter int PRE_MIN = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       serial_mode,
  input  logic [1:0] duplex_mode,
  input  logic       tx_tick,
  input  logic       rec_tick,
  input  logic       mac_tx_en,
  input  logic       mac_tx_er,
  input  logic [3:0] mac_txd,
  input  logic       line_rx_bit,
  input  logic       line_rx_act,
  input  logic       line_rx_err,
  output logic       line_tx_bit,
  output logic       line_tx_act,
  output logic       rx_clk_sel,
  output logic       rx_clk_en,
  output logic       mac_rx_dv,
  output logic       mac_rx_er,
  output logic [3:0] mac_rxd,
  output logic       mac_crs,
  output logic       mac_col
);
  localparam int CW = $clog2(PRE_MIN + 1);
  localparam logic [CW-1:0] RUN_TOP = CW'(PRE_MIN);

  logic [CW-1:0] run_len;
  logic          prev_bit;
  logic          rx_bit0;
  logic          half_dx;
  logic          unused_lanes;

  assign unused_lanes = ^{mac_txd[3:1], mac_tx_er};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      line_tx_act <= 1'b0;
      line_tx_bit <= 1'b0;
    end else if (tx_tick) begin
      line_tx_act <= serial_mode & mac_tx_en;
      line_tx_bit <= serial_mode & mac_tx_en & mac_txd[0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          rx_clk_sel <= 1'b0;
    else if (!mac_rx_dv) rx_clk_sel <= serial_mode & line_rx_act;

  assign rx_clk_en = rx_clk_sel ? rec_tick : tx_tick;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mac_rx_dv <= 1'b0;
      run_len   <= '0;
      prev_bit  <= 1'b0;
      rx_bit0   <= 1'b0;
    end else if (!serial_mode || !line_rx_act || line_rx_err) begin
      mac_rx_dv <= 1'b0;
      run_len   <= '0;
      prev_bit  <= 1'b0;
      rx_bit0   <= 1'b0;
    end else if (rx_clk_en) begin
      prev_bit <= line_rx_bit;
      if (mac_rx_dv)
        rx_bit0 <= line_rx_bit;
      else if (run_len == '0)
        run_len <= CW'(1);
      else if (line_rx_bit != prev_bit)
        run_len <= (run_len == RUN_TOP) ? run_len : run_len + CW'(1);
      else if (line_rx_bit && run_len >= RUN_TOP)
        mac_rx_dv <= 1'b1;
      else
        run_len <= CW'(1);
    end

  assign mac_rxd   = {3'b000, rx_bit0};
  assign mac_rx_er = 1'b0;

  assign half_dx = (duplex_mode == 2'b00);
  assign mac_crs = serial_mode & (line_rx_act | (half_dx & line_tx_act));
  assign mac_col = serial_mode & half_dx & line_tx_act & line_rx_act;

  assert_txact_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tx_tick) |-> $stable(line_tx_act));

  assert_sel_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mac_rx_dv) |-> rx_clk_sel == $past(rx_clk_sel));

  assert_dv_on_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mac_rx_dv) |-> $past(rx_clk_en));

  assert_dv_carrier_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mac_rx_dv |-> $past(line_rx_act && !line_rx_err));

  assert_col_crs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mac_col |-> mac_crs);

  assert_dv_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mac_rx_dv) |-> $past(serial_mode));
endmodule

// File: tb/serphy_ctrl_bench.sv
module serphy_ctrl_bench;
  logic clk = 0, rst_n = 0;
  logic serial_mode = 1, tx_tick = 0, rec_tick = 0;
  logic [1:0] duplex_mode = 2'b00;
  logic mac_tx_en = 0, mac_tx_er = 0;
  logic [3:0] mac_txd = 4'h0;
  logic line_rx_bit = 0, line_rx_act = 0, line_rx_err = 0;
  logic line_tx_bit, line_tx_act, rx_clk_sel, rx_clk_en, mac_rx_dv, mac_rx_er;
  logic [3:0] mac_rxd;
  logic mac_crs, mac_col;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  serphy_ctrl #(.PRE_MIN(4)) u_serphy_ctrl (
    .clk(clk), .rst_n(rst_n), .serial_mode(serial_mode), .duplex_mode(duplex_mode),
    .tx_tick(tx_tick), .rec_tick(rec_tick), .mac_tx_en(mac_tx_en), .mac_tx_er(mac_tx_er),
    .mac_txd(mac_txd), .line_rx_bit(line_rx_bit), .line_rx_act(line_rx_act),
    .line_rx_err(line_rx_err), .line_tx_bit(line_tx_bit), .line_tx_act(line_tx_act),
    .rx_clk_sel(rx_clk_sel), .rx_clk_en(rx_clk_en), .mac_rx_dv(mac_rx_dv),
    .mac_rx_er(mac_rx_er), .mac_rxd(mac_rxd), .mac_crs(mac_crs), .mac_col(mac_col));

  // {duplex_mode, tx_en, rx_act, crs, col}
  localparam logic [5:0] VEC [12] = '{
    6'b00_00_00, 6'b00_10_10, 6'b00_01_10, 6'b00_11_11,
    6'b01_00_00, 6'b01_10_00, 6'b01_01_10, 6'b01_11_10,
    6'b10_00_00, 6'b10_10_00, 6'b10_01_10, 6'b10_11_10};

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tx_pulse();
    @(negedge clk) tx_tick = 1;
    @(negedge clk) tx_tick = 0;
  endtask

  task automatic rx_bit(logic b);
    @(negedge clk) begin line_rx_bit = b; rec_tick = 1; end
    @(negedge clk) rec_tick = 0;
  endtask

  task automatic carrier(logic on);
    @(negedge clk) line_rx_act = on;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset dv", {7'd0, mac_rx_dv}, 8'd0);
    chk("R1 reset tx_act", {7'd0, line_tx_act}, 8'd0);
    chk("R3 reset sel", {7'd0, rx_clk_sel}, 8'd0);
    @(negedge clk) rst_n = 1;

    for (int i = 0; i < 12; i++) begin
      @(negedge clk) begin
        duplex_mode = VEC[i][5:4]; mac_tx_en = VEC[i][3]; line_rx_act = VEC[i][2];
      end
      tx_pulse();
      chk(VEC[i][5:4] == 2'b00 ? "R7 crs half" : "R8 crs rx-only", {7'd0, mac_crs}, {7'd0, VEC[i][1]});
      chk("R9 col", {7'd0, mac_col}, {7'd0, VEC[i][0]});
    end
    @(negedge clk) begin mac_tx_en = 0; line_rx_act = 0; duplex_mode = 2'b00; end
    tx_pulse();

    // R1 / R2 transmit path
    @(negedge clk) begin mac_tx_en = 1; mac_txd = 4'b1110; mac_tx_er = 1; end
    @(negedge clk);
    chk("R1 hold between strobes", {7'd0, line_tx_act}, 8'd0);
    tx_pulse();
    chk("R1 tx_act", {7'd0, line_tx_act}, 8'd1);
    chk("R2 lanes ignored bit0=0", {7'd0, line_tx_bit}, 8'd0);
    @(negedge clk) begin mac_txd = 4'b0001; mac_tx_er = 0; end
    tx_pulse();
    chk("R1 tx_bit", {7'd0, line_tx_bit}, 8'd1);
    @(negedge clk) mac_txd = 4'b1111;
    tx_pulse();
    chk("R2 lanes ignored bit0=1", {7'd0, line_tx_bit}, 8'd1);
    @(negedge clk) mac_tx_en = 0;
    tx_pulse();
    chk("R1 enable low", {6'd0, line_tx_act, line_tx_bit}, 8'd0);

    // R3 / R4 short preamble then boundary preamble
    carrier(1);
    chk("R3 sel recovered", {7'd0, rx_clk_sel}, 8'd1);
    rx_bit(1); rx_bit(0); rx_bit(1); rx_bit(1); rx_bit(1);
    chk("R4 run of 3 rejected", {7'd0, mac_rx_dv}, 8'd0);
    carrier(0);
    chk("R3 sel back to tx", {7'd0, rx_clk_sel}, 8'd0);
    carrier(1);
    rx_bit(0); rx_bit(1); rx_bit(0); rx_bit(1);
    chk("R4 no dv before closing 1", {7'd0, mac_rx_dv}, 8'd0);
    rx_bit(1);
    chk("R4 run of 4 accepted", {7'd0, mac_rx_dv}, 8'd1);
    rx_bit(1);
    chk("R5 data 1", {4'd0, mac_rxd}, 8'h01);
    @(negedge clk) line_rx_bit = 0;
    tx_pulse();
    chk("R5 tx strobe ignored", {4'd0, mac_rxd}, 8'h01);
    rx_bit(0);
    chk("R5 data 0", {4'd0, mac_rxd}, 8'h00);
    chk("R2 rx_er low", {7'd0, mac_rx_er}, 8'd0);

    // R3 / R6 carrier loss
    @(negedge clk) line_rx_act = 0;
    @(negedge clk);
    chk("R6 dv drop on carrier loss", {7'd0, mac_rx_dv}, 8'd0);
    chk("R3 sel held through dv", {7'd0, rx_clk_sel}, 8'd1);
    @(negedge clk);
    chk("R3 sel switches after dv", {7'd0, rx_clk_sel}, 8'd0);

    // long saturating preamble, then signal error
    carrier(1);
    for (int k = 0; k < 9; k++) rx_bit(k[0] ? 1'b0 : 1'b1);
    rx_bit(1);
    chk("R4 long preamble", {7'd0, mac_rx_dv}, 8'd1);
    @(negedge clk) line_rx_err = 1;
    @(negedge clk) line_rx_err = 0;
    chk("R6 dv drop on error", {7'd0, mac_rx_dv}, 8'd0);
    carrier(0);

    // R10 nibble mode
    @(negedge clk) begin serial_mode = 0; mac_tx_en = 1; end
    tx_pulse();
    carrier(1);
    rx_bit(0); rx_bit(1); rx_bit(0); rx_bit(1); rx_bit(1);
    chk("R10 idle tx", {7'd0, line_tx_act}, 8'd0);
    chk("R10 idle rx", {5'd0, mac_rx_dv, mac_crs, mac_col}, 8'd0);
    chk("R10 idle sel", {7'd0, rx_clk_sel}, 8'd0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule